// File: doc/BRIEF.md
# External Interrupt Request Sensing and Priority Selection

This block watches six external interrupt request pins. Each pin has its own sense mode: low level, high level, falling edge or rising edge. A pin in an edge mode sets a pending flag that stays set until software clears it. A pin in a level mode is never latched, so its request follows the filtered pin state.

Every input has a 4-bit priority. The block picks the active input with the highest priority and compares that priority with the 4-bit CPU mask level. When the priority is above the mask, it raises an interrupt request and reports the winning source number and its level.

A separate standby wake-up output is driven only by inputs 0 to 4. Software uses a small register bus to set the sense modes and priorities, to read the request flags and to clear them.

Each pin passes through a two-flop synchronizer and a hold filter. A per-input state machine holds the edge flag. It has three states: `PND_IDLE`, `PND_SET` and `PND_ARMED`. Its transitions are:
- IDLE→SET on an accepted edge in the selected direction.
- SET→ARMED on a read of the request register.
- ARMED→IDLE on a write of 0 to the input's bit.
- ARMED→SET when a write of 0 arrives in the same cycle as a new accepted edge.

Every other case holds the current state. That includes a write of 0 while in SET, a write of 1 in any state, and an edge while in SET or ARMED.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset all four registers read 0. Every input is in low-level mode with priority 0, and `irq_req`, `irq_lvl`, `irq_src` and `wake` are 0.
- R2: The sense register is at address 0. Bits [2i+1:2i] set the mode of input i: 00 low level, 01 high level, 10 falling edge, 11 rising edge. It reads back what was written in bits [11:0], and the other bits read 0.
- R3: In an edge mode, an active pin pulse held for at least two clocks sets the input's pending flag. A pulse of one clock is ignored.
- R4: The request register is at address 3 and bit i is input i. An edge flag clears only when a read of that register has returned the flag as 1 and a later write puts 0 in bit i. A write of 0 with no read before it has no effect, and a write of 1 has no effect.
- R5: In a level mode, request bit i and the request follow the filtered pin. A write of 0 to the request register does not remove a level request while the pin stays active.
- R6: Priorities are held at address 1 (inputs 0–3 in nibbles [3:0], [7:4], [11:8], [15:12]) and at address 2 (input 4 in [3:0], input 5 in [7:4]; bits [15:8] read 0). Priority 0 disables an input.
- R7: `irq_lvl` is the highest priority among active inputs, or 0 if there is none. `irq_src` is that input, with ties going to the lower number, or 0 if there is none.
- R8: `irq_req` is 1 exactly when `irq_lvl` is greater than `cpu_mask`. The block only reads the mask and never drives it.
- R9: `wake` is 1 exactly when `wake_en` is 1 and some active input among 0 to 4 has a priority greater than `cpu_mask`. Input 5 never raises `wake`.
- R10: An acknowledge pulse (`ack_valid`, `ack_src`) does not change any pending flag.
- R11: A pin change held long enough shows at the outputs after the fourth rising clock edge that samples the new level, and not after the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pin | input | 6 | External request pins, asynchronous |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (arms request flags read as 1) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| cpu_mask | input | 4 | Current CPU interrupt mask level |
| wake_en | input | 1 | Enables the standby wake-up output |
| ack_valid | input | 1 | Interrupt acknowledge pulse |
| ack_src | input | 3 | Source number being acknowledged |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_src | output | 3 | Winning source number |
| irq_lvl | output | 4 | Winning priority level |
| wake | output | 1 | Standby wake-up request |

## Verification
A flag machine stuck in SET or ARMED shows as an `irq_req` that a write of 0 cannot remove. A machine that never leaves IDLE shows as a missing request four clocks after a two-clock pulse. A filter that lets one-clock pulses through raises `irq_req` about four clocks after a glitch that should have been ignored. Arbitration or mask errors show on `irq_src`, `irq_lvl` and `wake` in the same cycle as the priority or mask change, so the sweep over pin patterns, priorities and masks exposes them at once.

// File: rtl/irqp_pkg.sv
package irqp_pkg;
    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_HIGH = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    typedef enum logic [1:0] {
        PND_IDLE  = 2'd0,
        PND_SET   = 2'd1,
        PND_ARMED = 2'd2
    } pend_e;
endpackage

// File: rtl/irqp_filter.sv
module irqp_filter #(
    parameter int  SYNC_LEN = 3,
    parameter logic RST_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic lvl,
    output logic chg,
    output logic new_lvl
);
    logic [SYNC_LEN-1:0] s_q;
    logic                lvl_q;
    logic                held;

    // the last two synchronized samples agree: the level has been held two clocks
    assign held    = (s_q[SYNC_LEN-1] == s_q[SYNC_LEN-2]);
    assign new_lvl = s_q[SYNC_LEN-2];
    assign chg     = held && (new_lvl != lvl_q);
    assign lvl     = lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q   <= {SYNC_LEN{RST_LVL}};
            lvl_q <= RST_LVL;
        end else begin
            s_q <= {s_q[SYNC_LEN-2:0], pin};
            if (chg) lvl_q <= new_lvl;
        end
    end
endmodule

// File: rtl/irqp_pending.sv
module irqp_pending
    import irqp_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  sense_e mode,
    input  logic   lvl,
    input  logic   chg,
    input  logic   new_lvl,
    input  logic   rd_strobe,
    input  logic   clr_strobe,
    output logic   active,
    output logic   held
);
    pend_e state_q, state_d;
    logic  edge_hit;
    logic  level_hit;
    logic  edge_mode;

    assign edge_mode = mode[1];
    assign edge_hit  = chg && ((mode == SENSE_RISE && new_lvl) || (mode == SENSE_FALL && !new_lvl));
    assign level_hit = (mode == SENSE_HIGH) ? lvl : !lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PND_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PND_IDLE:  if (edge_hit) state_d = PND_SET;
            PND_SET:   if (rd_strobe) state_d = PND_ARMED;
            PND_ARMED: if (clr_strobe) state_d = edge_hit ? PND_SET : PND_IDLE;
            default:   state_d = PND_IDLE;
        endcase
    end

    always_comb begin
        held   = (state_q != PND_IDLE);
        active = edge_mode ? held : (mode == SENSE_LOW || mode == SENSE_HIGH) && level_hit;
    end

    assert_set_not_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PND_SET) |=> (state_q != PND_IDLE));
    assert_arm_needs_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PND_SET && !rd_strobe) |=> (state_q == PND_SET));
    assert_level_no_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PND_IDLE && !edge_mode) |=> (state_q == PND_IDLE));
endmodule

// File: rtl/irqp_arbiter.sv
module irqp_arbiter #(
    parameter int N_SRC  = 6,
    parameter int N_WAKE = 5,
    parameter int PW     = 4,
    parameter int SW     = 3
) (
    input  logic [N_SRC-1:0]         active,
    input  logic [N_SRC-1:0][PW-1:0] prio,
    input  logic [PW-1:0]            mask,
    input  logic                     wake_en,
    output logic                     irq_req,
    output logic [SW-1:0]            irq_src,
    output logic [PW-1:0]            irq_lvl,
    output logic                     wake
);
    logic [N_WAKE-1:0] wake_hit;

    // strict compare keeps the lower-numbered input on a tie; priority 0 never wins
    always_comb begin
        irq_lvl = '0;
        irq_src = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (active[i] && prio[i] > irq_lvl) begin
                irq_lvl = prio[i];
                irq_src = SW'(i);
            end
        end
    end

    assign irq_req = (irq_lvl > mask);

    for (genvar g = 0; g < N_WAKE; g++) begin : g_wake
        assign wake_hit[g] = active[g] && (prio[g] > mask);
    end

    assign wake = wake_en && (|wake_hit);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irqp_pkg::*;
#(
    parameter int N_SRC  = 6,
    parameter int N_WAKE = 5,
    parameter int PW     = 4,
    parameter int DW     = 16,
    parameter int AW     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [5:0]       irq_pin,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [PW-1:0]    cpu_mask,
    input  logic             wake_en,
    input  logic             ack_valid,
    input  logic [2:0]       ack_src,
    output logic             irq_req,
    output logic [2:0]       irq_src,
    output logic [PW-1:0]    irq_lvl,
    output logic             wake
);
    localparam int SW       = $clog2(N_SRC);
    localparam int PER_REG  = DW / PW;
    localparam int N_PREG   = (N_SRC + PER_REG - 1) / PER_REG;
    localparam int REQ_ADDR = N_PREG + 1;
    localparam int SNS_W    = 2 * N_SRC;

    logic [SNS_W-1:0]          sense_q;
    logic [N_SRC-1:0][PW-1:0]  prio_q;
    logic [N_SRC-1:0]          act_vec;
    logic [N_SRC-1:0]          pend_vec;
    logic                      req_rd;
    logic                      req_wr;

    assign req_rd = bus_rd && (bus_addr == AW'(REQ_ADDR));
    assign req_wr = bus_wr && (bus_addr == AW'(REQ_ADDR));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sense_q <= '0;
            prio_q  <= '0;
        end else if (bus_wr) begin
            if (bus_addr == AW'(0)) sense_q <= bus_wdata[SNS_W-1:0];
            for (int i = 0; i < N_SRC; i++) begin
                if (bus_addr == AW'(1 + i / PER_REG))
                    prio_q[i] <= bus_wdata[(i % PER_REG) * PW +: PW];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(0)) begin
            bus_rdata[SNS_W-1:0] = sense_q;
        end else if (bus_addr == AW'(REQ_ADDR)) begin
            bus_rdata[N_SRC-1:0] = act_vec;
        end else begin
            for (int i = 0; i < N_SRC; i++) begin
                if (bus_addr == AW'(1 + i / PER_REG))
                    bus_rdata[(i % PER_REG) * PW +: PW] = prio_q[i];
            end
        end
    end

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        logic f_lvl, f_chg, f_new;

        irqp_filter #(.SYNC_LEN(3), .RST_LVL(1'b1)) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin     (irq_pin[g]),
            .lvl     (f_lvl),
            .chg     (f_chg),
            .new_lvl (f_new)
        );

        irqp_pending u_pend (
            .clk        (clk),
            .rst_n      (rst_n),
            .mode       (sense_e'(sense_q[2*g +: 2])),
            .lvl        (f_lvl),
            .chg        (f_chg),
            .new_lvl    (f_new),
            .rd_strobe  (req_rd),
            .clr_strobe (req_wr && !bus_wdata[g]),
            .active     (act_vec[g]),
            .held       (pend_vec[g])
        );
    end

    irqp_arbiter #(.N_SRC(N_SRC), .N_WAKE(N_WAKE), .PW(PW), .SW(SW)) u_arb (
        .active  (act_vec),
        .prio    (prio_q),
        .mask    (cpu_mask),
        .wake_en (wake_en),
        .irq_req (irq_req),
        .irq_src (irq_src),
        .irq_lvl (irq_lvl),
        .wake    (wake)
    );

    assert_req_above_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_lvl > cpu_mask));
    assert_winner_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> act_vec[irq_src]);
    assert_wake_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (wake_en && (|act_vec[N_WAKE-1:0])));
    assert_ack_keeps_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_src < 3'(N_SRC) && !req_wr) |=> ((pend_vec & $past(pend_vec)) == $past(pend_vec)));
endmodule

// File: tb/tb_irq_prio_ctrl.sv
`timescale 1ns/1ps
module tb_irq_prio_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  irq_pin = 6'h3F;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [3:0]  cpu_mask = '0;
    logic        wake_en = 1'b0;
    logic        ack_valid = 1'b0;
    logic [2:0]  ack_src = '0;
    logic        irq_req;
    logic [2:0]  irq_src;
    logic [3:0]  irq_lvl;
    logic        wake;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    irq_prio_ctrl dut (
        .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cpu_mask(cpu_mask), .wake_en(wake_en), .ack_valid(ack_valid), .ack_src(ack_src),
        .irq_req(irq_req), .irq_src(irq_src), .irq_lvl(irq_lvl), .wake(wake)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [15:0] d;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);

        // R1: reset state
        check("R1 irq_req", irq_req, 0);
        check("R1 irq_lvl", irq_lvl, 0);
        check("R1 irq_src", irq_src, 0);
        check("R1 wake", wake, 0);
        for (int a = 0; a < 4; a++) begin
            bus_read(2'(a), d);
            check("R1 register reads 0", d, 0);
        end

        // R2/R6 register layout
        bus_write(0, 16'hFABC);
        bus_read(0, d);
        check("R2 sense readback", d, 16'h0ABC);
        bus_write(0, 16'h0000);
        bus_write(2, 16'hFFFF);
        bus_read(2, d);
        check("R6 upper priority reg", d, 16'h00FF);
        bus_write(1, 16'h4321);
        bus_write(2, 16'h0065);
        bus_read(1, d);
        check("R6 lower priority reg", d, 16'h4321);

        // per-input, per-mode sweep
        for (int i = 0; i < 6; i++) begin
            for (int m = 0; m < 4; m++) begin
                logic idle, actv;
                idle = (m == 0 || m == 2);
                actv = ~idle;
                @(negedge clk);
                irq_pin = 6'h3F;
                irq_pin[i] = idle;
                cpu_mask = 0;
                wait_cyc(6);
                bus_write(0, 16'(m << (2 * i)));
                wait_cyc(6);
                bus_read(3, d);
                bus_write(3, 16'h0000);
                check("R2 idle pin gives no request", irq_req, 0);
                if (m >= 2) begin
                    // R3: one-clock pulse ignored
                    irq_pin[i] = actv; wait_cyc(1); irq_pin[i] = idle;
                    wait_cyc(6);
                    check("R3 short pulse ignored", irq_req, 0);
                    // two-clock pulse, R11 latency
                    irq_pin[i] = actv; wait_cyc(2); irq_pin[i] = idle;
                    wait_cyc(1);
                    check("R11 not after third edge", irq_req, 0);
                    wait_cyc(1);
                    check("R3 two-clock pulse latched", irq_req, 1);
                    check("R7 source", irq_src, i);
                    check("R8 level", irq_lvl, i + 1);
                    wait_cyc(6);
                    check("R4 flag holds after pin idle", irq_req, 1);
                    ack_valid = 1'b1; ack_src = 3'(i);
                    wait_cyc(1);
                    ack_valid = 1'b0;
                    wait_cyc(2);
                    check("R10 ack keeps flag", irq_req, 1);
                    bus_write(3, 16'h0000);
                    check("R4 write 0 without read ignored", irq_req, 1);
                    bus_read(3, d);
                    check("R4 read shows flag", d[i], 1);
                    bus_write(3, 16'(1 << i));
                    check("R4 write 1 ignored", irq_req, 1);
                    bus_write(3, 16'h0000);
                    check("R4 read-then-write-0 clears", irq_req, 0);
                end else begin
                    irq_pin[i] = actv;
                    wait_cyc(3);
                    check("R11 level not after third edge", irq_req, 0);
                    wait_cyc(1);
                    check("R5 level request", irq_req, 1);
                    check("R5 level source", irq_src, i);
                    bus_read(3, d);
                    check("R5 request bit live", d[i], 1);
                    bus_write(3, 16'h0000);
                    check("R5 write 0 keeps level", irq_req, 1);
                    irq_pin[i] = idle;
                    wait_cyc(3);
                    check("R11 level release latency", irq_req, 1);
                    wait_cyc(1);
                    check("R5 level follows pin", irq_req, 0);
                end
            end
        end

        // arbitration sweep, all inputs high-level mode
        bus_write(0, 16'h0555);
        for (int t = 0; t < 48; t++) begin
            logic [3:0] p [6];
            logic [5:0] pins;
            logic [3:0] msk, best;
            logic [2:0] src;
            logic       we, exp_wake;
            for (int i = 0; i < 6; i++) p[i] = 4'((t * 7 + i * 5 + (t * i) % 3) % 16);
            if (t == 46) for (int i = 0; i < 6; i++) p[i] = 4'd7;
            pins = 6'((t * 13 + 5) % 64);
            if (t == 46) pins = 6'b110110;
            msk  = 4'((t * 3) % 10);
            we   = (t % 4 != 3);
            if (t == 47) begin
                p[5] = 4'd15; pins = 6'b100000; msk = 0; we = 1;
            end
            bus_write(1, {p[3], p[2], p[1], p[0]});
            bus_write(2, {8'h00, p[5], p[4]});
            @(negedge clk);
            irq_pin = pins; cpu_mask = msk; wake_en = we;
            wait_cyc(6);
            best = 0; src = 0; exp_wake = 0;
            for (int i = 0; i < 6; i++) begin
                if (pins[i] && p[i] > best) begin best = p[i]; src = 3'(i); end
                if (i < 5 && pins[i] && p[i] > msk) exp_wake = we;
            end
            check("R7 winning level", irq_lvl, best);
            check("R7 winning source", irq_src, src);
            check("R8 request vs mask", irq_req, best > msk);
            check("R9 wake", wake, exp_wake);
        end

        done = 1;
        finish_run();
    end
endmodule